// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This block runs the whole erase procedure for a single block of an embedded flash array, so that software only has to issue a start command. It drives the array's control strobes (write enable, erase setup, erase pulse, erase verify), keeps a watchdog enable high around every erase pulse, and holds the block select lines steady while the array is being worked on. Each strobe change is separated from the next by a wait whose length is a parameter counted in clock cycles. One shared down-counter times all of these waits.

After each erase pulse the sequencer enters verify mode. It steps through the selected block one 16-bit word at a time. For each word it writes a dummy all-ones value, waits, and then reads the word back. A word passes only if every bit reads 1. The first word that fails ends that verify pass. If the attempt limit has not yet been reached, another pulse is applied. Once every word passes, the sequencer leaves with a done pulse. When the limit is reached, it leaves with a fail pulse instead. Both exits report how many pulses were used. A start whose block select is not one-hot is refused at once and drives no strobe.

States and transitions: IDLE goes to SWE_ON on an accepted start. The erase chain then runs SWE_ON, ESU_ON, ERS_ON, ERS_OFF, ESU_OFF and EV_ON. The verify loop runs VWR, VWAIT and VRD. VRD goes back to VWR when a word passes and it is not the last word. VRD goes to EV_RETRY when a word fails below the limit, and EV_RETRY leads back to ESU_ON. VRD goes to EV_EXIT when the last word passes or when a word fails at the limit. The exit then runs EV_EXIT, SWE_OFF and REPORT, and returns to IDLE.

Top module: `blk_erase_seq`

## Requirements
- R1: While reset is applied, and after its release with no start, all strobes, `blk_en`, `busy`, `done`, `fail` and `sel_err` are 0.
- R2: If a start arrives while `blk_sel` has zero bits or more than one bit set, `sel_err` pulses high in the next cycle, `busy` stays 0 and no flash strobe rises.
- R3: `fl_swe` rises first. `fl_esu` rises exactly T_SSWE cycles later, and `fl_esu`/`fl_ev` are only ever high while `fl_swe` is high.
- R4: In each attempt, `fl_ers` rises T_SESU cycles after `fl_esu` and stays high for exactly T_SE cycles. `fl_esu` falls T_CE cycles after `fl_ers` falls. `fl_ers` is never high without `fl_esu`.
- R5: `wdg_en` is high whenever `fl_esu` is high, and it falls T_CESU cycles after `fl_esu` falls.
- R6: The first dummy write (`fl_wr`, data 16'hFFFF) comes T_SEV cycles after `fl_ev` rises, at address block_index*BLK_WORDS (address = {block index, word index}). Each read (`fl_rd`) follows its write by T_SEVR+1 cycles. `fl_ev` is never high together with `fl_esu`.
- R7: A word passes only if it reads 16'hFFFF. The first failing word ends that verify pass with no further reads, and another erase pulse follows while attempts are below N_MAX.
- R8: If a word fails on attempt N_MAX, `fail` pulses for one cycle and `attempts` equals N_MAX. `attempts` never exceeds N_MAX.
- R9: When all BLK_WORDS words pass, `done` pulses for one cycle and `attempts` equals the number of erase pulses applied.
- R10: On exit, `fl_swe` falls T_CEV cycles after `fl_ev` falls, and `done`/`fail` pulse T_CSWE cycles after that. `busy` is high from the cycle after the accepted start until the report cycle, in which it is 0.
- R11: `blk_en` is one-hot or zero, and it equals the accepted block select whenever `fl_esu` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled in IDLE |
| blk_sel | input | NBLK | Block to erase, must be one-hot |
| fl_rdata | input | DW | Read data from the array |
| fl_swe | output | 1 | Array write enable |
| fl_esu | output | 1 | Erase setup strobe |
| fl_ers | output | 1 | Erase pulse strobe |
| fl_ev | output | 1 | Erase verify mode |
| wdg_en | output | 1 | Watchdog enable around the erase pulse |
| blk_en | output | NBLK | Block select to the array |
| fl_addr | output | AW | Word address for verify |
| fl_wr | output | 1 | Dummy write strobe |
| fl_wdata | output | DW | Dummy write data (all ones) |
| fl_rd | output | 1 | Verify read strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle erase success pulse |
| fail | output | 1 | One-cycle erase failure pulse |
| sel_err | output | 1 | One-cycle rejected-select pulse |
| attempts | output | CW | Erase pulses used in the last run |

## Verification
The hardest path to reach is the retry loop. In it a verify pass stops early at a failing word and then re-enters the erase chain. Reaching that path on the last permitted attempt, which must give a fail exit, is harder still. The bench's behavioural array holds one chosen word of the chosen block at a value with a single 0 bit. That word is released to all ones only after a programmed number of erase pulses. By varying the word's position and the pulse count, including counts at and above N_MAX, the stimulus drives early exits at the first and last word, exact-limit success and limit failure. The read count and attempt count are then compared with values derived from the position and the pulse count.

// File: rtl/blk_erase_pkg.sv
package blk_erase_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_SWE_ON, S_ESU_ON, S_ERS_ON, S_ERS_OFF, S_ESU_OFF, S_EV_ON,
        S_VWR, S_VWAIT, S_VRD, S_EV_RETRY, S_EV_EXIT, S_SWE_OFF, S_REPORT
    } seq_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/erase_wait_timer.sv
module erase_wait_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/erase_sel_check.sv
module erase_sel_check #(
    parameter int NBLK = 4,
    parameter int IW   = 2
) (
    input  logic [NBLK-1:0] sel,
    output logic            onehot,
    output logic [IW-1:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < NBLK; i++) begin
            if (sel[i]) idx = IW'(i);
        end
    end

    assign onehot = $onehot(sel);
endmodule

// File: rtl/erase_attempt_ctr.sv
module erase_attempt_ctr #(
    parameter int N_MAX = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          at_max
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  count <= '0;
        else if (clr)                count <= '0;
        else if (inc && !at_max)     count <= count + 1'b1;
    end

    assign at_max = (count >= CW'(N_MAX));
endmodule

// File: rtl/blk_erase_seq.sv
module blk_erase_seq
    import blk_erase_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int BLK_WORDS = 8,
    parameter int DW        = 16,
    parameter int N_MAX     = 4,
    parameter int T_SSWE    = 3,
    parameter int T_SESU    = 2,
    parameter int T_SE      = 6,
    parameter int T_CE      = 2,
    parameter int T_CESU    = 2,
    parameter int T_SEV     = 2,
    parameter int T_SEVR    = 2,
    parameter int T_CEV     = 2,
    parameter int T_CSWE    = 3,
    localparam int IW       = $clog2(NBLK),
    localparam int WW       = $clog2(BLK_WORDS),
    localparam int AW       = IW + WW,
    localparam int CW       = $clog2(N_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NBLK-1:0] blk_sel,
    input  logic [DW-1:0]   fl_rdata,
    output logic            fl_swe,
    output logic            fl_esu,
    output logic            fl_ers,
    output logic            fl_ev,
    output logic            wdg_en,
    output logic [NBLK-1:0] blk_en,
    output logic [AW-1:0]   fl_addr,
    output logic            fl_wr,
    output logic [DW-1:0]   fl_wdata,
    output logic            fl_rd,
    output logic            busy,
    output logic            done,
    output logic            fail,
    output logic            sel_err,
    output logic [CW-1:0]   attempts
);
    localparam int T_MAX = imax(imax(imax(T_SSWE, T_SESU), imax(T_SE, T_CE)),
                           imax(imax(T_CESU, T_SEV), imax(imax(T_SEVR, T_CEV), T_CSWE)));
    localparam int TW    = $clog2(T_MAX + 1);

    seq_state_t state_q, state_d;

    logic            t_load, t_exp;
    logic [TW-1:0]   t_val;
    logic            sel_ok;
    logic [IW-1:0]   sel_idx;
    logic [IW-1:0]   idx_q;
    logic [WW-1:0]   word_q;
    logic [NBLK-1:0] sel_q;
    logic            ok_q, sel_err_q;
    logic            att_max;
    logic            accept, word_pass, word_last, enter;

    assign accept    = (state_q == S_IDLE) && start && sel_ok;
    assign word_pass = (fl_rdata == {DW{1'b1}});
    assign word_last = (word_q == WW'(BLK_WORDS - 1));
    assign enter     = (state_d != state_q);

    erase_sel_check #(.NBLK(NBLK), .IW(IW)) u_sel (
        .sel    (blk_sel),
        .onehot (sel_ok),
        .idx    (sel_idx)
    );

    erase_wait_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    erase_attempt_ctr #(.N_MAX(N_MAX), .CW(CW)) u_att (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .inc    (enter && (state_d == S_ESU_ON)),
        .count  (attempts),
        .at_max (att_max)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and wait reload
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (accept) state_d = S_SWE_ON;
            S_SWE_ON:   if (t_exp)  state_d = S_ESU_ON;
            S_ESU_ON:   if (t_exp)  state_d = S_ERS_ON;
            S_ERS_ON:   if (t_exp)  state_d = S_ERS_OFF;
            S_ERS_OFF:  if (t_exp)  state_d = S_ESU_OFF;
            S_ESU_OFF:  if (t_exp)  state_d = S_EV_ON;
            S_EV_ON:    if (t_exp)  state_d = S_VWR;
            S_VWR:                  state_d = S_VWAIT;
            S_VWAIT:    if (t_exp)  state_d = S_VRD;
            S_VRD: begin
                if (!word_pass)     state_d = att_max ? S_EV_EXIT : S_EV_RETRY;
                else if (word_last) state_d = S_EV_EXIT;
                else                state_d = S_VWR;
            end
            S_EV_RETRY: if (t_exp)  state_d = S_ESU_ON;
            S_EV_EXIT:  if (t_exp)  state_d = S_SWE_OFF;
            S_SWE_OFF:  if (t_exp)  state_d = S_REPORT;
            S_REPORT:               state_d = S_IDLE;
            default:                state_d = S_IDLE;
        endcase

        t_load = enter;
        unique case (state_d)
            S_SWE_ON:   t_val = TW'(T_SSWE - 1);
            S_ESU_ON:   t_val = TW'(T_SESU - 1);
            S_ERS_ON:   t_val = TW'(T_SE - 1);
            S_ERS_OFF:  t_val = TW'(T_CE - 1);
            S_ESU_OFF:  t_val = TW'(T_CESU - 1);
            S_EV_ON:    t_val = TW'(T_SEV - 1);
            S_VWAIT:    t_val = TW'(T_SEVR - 1);
            S_EV_RETRY,
            S_EV_EXIT:  t_val = TW'(T_CEV - 1);
            S_SWE_OFF:  t_val = TW'(T_CSWE - 1);
            default:    t_val = '0;
        endcase
    end

    // block, address and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            idx_q     <= '0;
            word_q    <= '0;
            ok_q      <= 1'b0;
            sel_err_q <= 1'b0;
        end else begin
            sel_err_q <= (state_q == S_IDLE) && start && !sel_ok;
            if (accept) begin
                sel_q <= blk_sel;
                idx_q <= sel_idx;
                ok_q  <= 1'b0;
            end
            if (enter && state_d == S_EV_ON) word_q <= '0;
            if (state_q == S_VRD) begin
                if (word_pass && !word_last) word_q <= word_q + 1'b1;
                ok_q <= word_pass && word_last;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        fl_swe   = 1'b0;
        fl_esu   = 1'b0;
        fl_ers   = 1'b0;
        fl_ev    = 1'b0;
        wdg_en   = 1'b0;
        fl_wr    = 1'b0;
        fl_rd    = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        fail     = 1'b0;
        unique case (state_q)
            S_IDLE:     busy = 1'b0;
            S_SWE_ON:   fl_swe = 1'b1;
            S_ESU_ON:   begin fl_swe = 1'b1; fl_esu = 1'b1; wdg_en = 1'b1; end
            S_ERS_ON:   begin fl_swe = 1'b1; fl_esu = 1'b1; wdg_en = 1'b1; fl_ers = 1'b1; end
            S_ERS_OFF:  begin fl_swe = 1'b1; fl_esu = 1'b1; wdg_en = 1'b1; end
            S_ESU_OFF:  begin fl_swe = 1'b1; wdg_en = 1'b1; end
            S_EV_ON:    begin fl_swe = 1'b1; fl_ev = 1'b1; end
            S_VWR:      begin fl_swe = 1'b1; fl_ev = 1'b1; fl_wr = 1'b1; end
            S_VWAIT:    begin fl_swe = 1'b1; fl_ev = 1'b1; end
            S_VRD:      begin fl_swe = 1'b1; fl_ev = 1'b1; fl_rd = 1'b1; end
            S_EV_RETRY,
            S_EV_EXIT:  fl_swe = 1'b1;
            S_SWE_OFF:  ;
            S_REPORT:   begin busy = 1'b0; done = ok_q; fail = !ok_q; end
            default:    busy = 1'b0;
        endcase
        blk_en   = (state_q inside {[S_ESU_ON:S_EV_EXIT]}) ? sel_q : '0;
        fl_addr  = {idx_q, word_q};
        fl_wdata = {DW{1'b1}};
        sel_err  = sel_err_q;
    end
endmodule

// File: rtl/blk_erase_seq_chk.sv
module blk_erase_seq_chk #(
    parameter int NBLK  = 4,
    parameter int N_MAX = 4,
    parameter int CW    = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fl_swe,
    input logic            fl_esu,
    input logic            fl_ers,
    input logic            fl_ev,
    input logic            wdg_en,
    input logic [NBLK-1:0] blk_en,
    input logic            busy,
    input logic            done,
    input logic            fail,
    input logic            sel_err,
    input logic [CW-1:0]   attempts
);
    p_strobe_needs_swe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_esu || fl_ev) |-> fl_swe);
    p_ers_needs_esu_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ers |-> fl_esu);
    p_wdg_covers_esu_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fl_esu |-> wdg_en);
    p_ev_apart_esu_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ev |-> !fl_esu);
    p_sel_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> (!fl_swe && !busy));
    p_attempt_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        attempts <= CW'(N_MAX));
    p_report_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));
    p_report_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> (!busy && $past(busy)));
    p_blk_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_en));
    p_blk_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_esu && $past(fl_esu)) |-> $stable(blk_en));
endmodule

bind blk_erase_seq blk_erase_seq_chk #(.NBLK(NBLK), .N_MAX(N_MAX), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fl_swe   (fl_swe),
    .fl_esu   (fl_esu),
    .fl_ers   (fl_ers),
    .fl_ev    (fl_ev),
    .wdg_en   (wdg_en),
    .blk_en   (blk_en),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .sel_err  (sel_err),
    .attempts (attempts)
);

// File: tb/tb_blk_erase_seq.sv
module tb_blk_erase_seq;
    localparam int NBLK = 4, BW = 8, DW = 16, NMX = 4;
    localparam int TSSWE = 3, TSESU = 2, TSE = 6, TCE = 2, TCESU = 2;
    localparam int TSEV = 2, TSEVR = 2, TCEV = 2, TCSWE = 3;
    localparam int AW = 5, CW = 3;
    localparam int NV = 6;
    // vectors: block, failing word, pulses needed before the word erases
    localparam int V_BLK [NV] = '{0, 1, 2, 3, 1, 2};
    localparam int V_BAD [NV] = '{0, 7, 3, 5, 0, 7};
    localparam int V_K   [NV] = '{1, 2, 4, 5, 0, 3};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [NBLK-1:0] blk_sel = '0;
    logic [DW-1:0] fl_rdata;
    logic fl_swe, fl_esu, fl_ers, fl_ev, wdg_en, fl_wr, fl_rd;
    logic busy, done, fail, sel_err;
    logic [NBLK-1:0] blk_en;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic [CW-1:0] attempts;

    int n_chk = 0, n_fail = 0;
    logic mon_clr = 1'b0;
    int cur_blk = 0, cur_bad = 0, cur_k = 0;

    always #2 clk = ~clk;

    blk_erase_seq #(.NBLK(NBLK), .BLK_WORDS(BW), .DW(DW), .N_MAX(NMX),
        .T_SSWE(TSSWE), .T_SESU(TSESU), .T_SE(TSE), .T_CE(TCE), .T_CESU(TCESU),
        .T_SEV(TSEV), .T_SEVR(TSEVR), .T_CEV(TCEV), .T_CSWE(TCSWE)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_sel(blk_sel), .fl_rdata(fl_rdata),
        .fl_swe(fl_swe), .fl_esu(fl_esu), .fl_ers(fl_ers), .fl_ev(fl_ev), .wdg_en(wdg_en),
        .blk_en(blk_en), .fl_addr(fl_addr), .fl_wr(fl_wr), .fl_wdata(fl_wdata), .fl_rd(fl_rd),
        .busy(busy), .done(done), .fail(fail), .sel_err(sel_err), .attempts(attempts));

    // monitor and behavioural array
    int cyc, t_swe_r, t_esu_r, t_ers_r, t_ers_f, t_esu_f, t_wdg_f, t_ev_r, t_wr1, t_rd1;
    int t_ev_f, t_swe_f, t_done, n_pulses, n_reads, ers_len, first_addr;
    int ers_bad, wd_bad, blk_bad, addr_bad;
    logic p_swe, p_esu, p_ers, p_ev, p_wdg;

    assign fl_rdata = (n_pulses >= cur_k || int'(fl_addr) != cur_blk * BW + cur_bad)
                      ? 16'hFFFF : 16'h7FFF;

    always @(negedge clk) begin
        if (mon_clr) begin
            cyc = 0; t_swe_r = -1; t_esu_r = -1; t_ers_r = -1; t_ers_f = -1; t_esu_f = -1;
            t_wdg_f = -1; t_ev_r = -1; t_wr1 = -1; t_rd1 = -1; t_ev_f = -1; t_swe_f = -1;
            t_done = -1; n_pulses = 0; n_reads = 0; ers_len = 0; first_addr = -1;
            ers_bad = 0; wd_bad = 0; blk_bad = 0; addr_bad = 0;
            p_swe = 0; p_esu = 0; p_ers = 0; p_ev = 0; p_wdg = 0;
        end else begin
            cyc++;
            if (fl_swe && !p_swe && t_swe_r < 0) t_swe_r = cyc;
            if (!fl_swe && p_swe) t_swe_f = cyc;
            if (fl_esu && !p_esu && t_esu_r < 0) t_esu_r = cyc;
            if (!fl_esu && p_esu && t_esu_f < 0) t_esu_f = cyc;
            if (!wdg_en && p_wdg && t_wdg_f < 0) t_wdg_f = cyc;
            if (fl_ers && !p_ers) begin
                n_pulses++;
                if (t_ers_r < 0) t_ers_r = cyc;
            end
            if (fl_ers) ers_len++;
            if (!fl_ers && p_ers) begin
                if (t_ers_f < 0) t_ers_f = cyc;
                if (ers_len != TSE) ers_bad++;
                ers_len = 0;
            end
            if (fl_ev && !p_ev && t_ev_r < 0) t_ev_r = cyc;
            if (!fl_ev && p_ev) t_ev_f = cyc;
            if (fl_wr) begin
                if (t_wr1 < 0) begin t_wr1 = cyc; first_addr = int'(fl_addr); end
                if (fl_wdata != 16'hFFFF) wd_bad++;
            end
            if (fl_rd) begin
                n_reads++;
                if (t_rd1 < 0) t_rd1 = cyc;
                if (int'(fl_addr) / BW != cur_blk) addr_bad++;
            end
            if (fl_esu && blk_en != NBLK'(1 << cur_blk)) blk_bad++;
            if ((done || fail) && t_done < 0) t_done = cyc;
            p_swe = fl_swe; p_esu = fl_esu; p_ers = fl_ers; p_ev = fl_ev; p_wdg = wdg_en;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic run_vec(input int blk, input int bad, input int k);
        int att, reads, lim;
        bit ok;
        cur_blk = blk; cur_bad = bad; cur_k = k;
        clear_mon();
        blk_sel = NBLK'(1 << blk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R10 busy after accept", int'(busy), 1);
        lim = 0;
        while (!(done || fail) && lim < 2000) begin @(negedge clk); lim++; end
        ok    = (k <= NMX);
        att   = (k == 0) ? 1 : (ok ? k : NMX);
        reads = ok ? (att - 1) * (bad + 1) + BW : NMX * (bad + 1);
        check(ok ? "R9 done" : "R8 fail", int'(ok ? done : fail), 1);
        check("R10 busy low at report", int'(busy), 0);
        check(ok ? "R9 attempts" : "R8 attempts", int'(attempts), att);
        @(negedge clk);
        check("R3 swe to esu", t_esu_r - t_swe_r, TSSWE);
        check("R4 esu to ers", t_ers_r - t_esu_r, TSESU);
        check("R4 ers width", ers_bad, 0);
        check("R4 ers fall to esu fall", t_esu_f - t_ers_f, TCE);
        check("R5 esu fall to wdg fall", t_wdg_f - t_esu_f, TCESU);
        check("R6 ev to first write", t_wr1 - t_ev_r, TSEV);
        check("R6 first address", first_addr, blk * BW);
        check("R6 write to read", t_rd1 - t_wr1, TSEVR + 1);
        check("R6 dummy data", wd_bad, 0);
        check("R7 read count", n_reads, reads);
        check("R7 read address in block", addr_bad, 0);
        check("R7 pulse count", n_pulses, att);
        check("R10 ev fall to swe fall", t_swe_f - t_ev_f, TCEV);
        check("R10 swe fall to report", t_done - t_swe_f, TCSWE);
        check("R11 block select", blk_bad, 0);
    endtask

    task automatic reject(input logic [NBLK-1:0] s);
        clear_mon();
        blk_sel = s; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R2 sel_err", int'(sel_err), 1);
        check("R2 busy", int'(busy), 0);
        repeat (6) @(negedge clk);
        check("R2 no strobe", t_swe_r, -1);
        check("R2 no block", int'(blk_en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset strobes", int'({fl_swe, fl_esu, fl_ers, fl_ev, wdg_en, fl_wr, fl_rd}), 0);
        check("R1 reset status", int'({busy, done, fail, sel_err, blk_en}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", int'({fl_swe, busy, done, fail, sel_err, blk_en}), 0);

        for (int v = 0; v < NV; v++) run_vec(V_BLK[v], V_BAD[v], V_K[v]);

        reject(4'b0000);
        reject(4'b0101);
        reject(4'b1111);

        // reset during the erase pulse
        cur_blk = 3; cur_bad = 0; cur_k = 1;
        blk_sel = 4'b1000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (TSSWE + TSESU + 1) @(negedge clk);
        check("R4 pulse running", int'(fl_ers), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", int'({fl_swe, fl_esu, fl_ers, wdg_en, busy, blk_en}), 0);
        rst_n = 1'b1;
        run_vec(2, 4, 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule